// File: doc/BRIEF.md
# Transmit FIFO Refill and Start Pacer

This block is the pacing logic that sits beside a transmit byte FIFO. It makes two decisions. The first is when to ask the buffer manager for more frame data. That request is raised whenever enough free space is open to hold a programmable number of 16-bit transfers. The second is when to tell the MAC to begin sending the current frame. That start is issued once enough bytes of the frame are in the FIFO, or at once when the whole frame is already resident. The FIFO storage, the DMA engine and the MAC lie outside the block.

Two 2-bit codes set the behaviour. A refill code selects the free-space threshold, in word slots. A start code selects the byte threshold for the current frame. Software loads both codes together through a write strobe. The block counts the bytes pushed for the current frame on its own. That count restarts when the transmitter reports that it has consumed the frame's end marker.

Top module: `txq_pacer`

## Requirements
- R1: `refill_req` is high in the cycle after an edge at which `free_bytes` held at least 2×S bytes and `src_dry` was low. S is the word-slot threshold of the latched refill code. Otherwise `refill_req` is low in that cycle.
- R2: Refill codes 00, 01 and 10 give S = 4, 8 and 16 word slots, which is 8, 16 and 32 free bytes. Code 11 acts exactly like 00.
- R3: Start codes 00, 01, 10 and 11 give start thresholds of 4, 16, 64 and 112 bytes of the current frame. `tx_go` pulses for one cycle at the clock edge after the edge at which the per-frame byte count first reaches the threshold.
- R4: When `frame_tail_in` is high at an edge and the frame has not yet started, `tx_go` pulses at that same edge, whatever the byte count and the start code.
- R5: `tx_go` pulses at most once per frame. No further pulse follows, from the threshold or from the tail flag, until `eof_taken` ends the frame.
- R6: When `src_dry` is high at an edge, `refill_req` is low after that edge, whatever the free space.
- R7: After reset, `refill_req` and `tx_go` are low. The latched refill code is 00. The latched start code is 10, so a frame starts at 64 bytes.
- R8: Both codes are latched from `wm_sel` and `sp_sel` only at an edge where `cfg_we` is high. Changes on `wm_sel` or `sp_sel` at other times have no effect.
- R9: At an edge where `eof_taken` is high, the per-frame count restarts at the value of `push_bytes` in that cycle. Bytes counted before that edge belong to the old frame and no longer count toward the start. At every other edge the count adds `push_bytes` and saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Latch both threshold codes |
| wm_sel | input | 2 | Refill threshold code to latch |
| sp_sel | input | 2 | Start threshold code to latch |
| free_bytes | input | CNT_W | Empty bytes in the FIFO |
| push_bytes | input | 2 | Bytes of the current frame written this cycle |
| frame_tail_in | input | 1 | Whole current frame is in the FIFO |
| eof_taken | input | 1 | Transmitter consumed the frame's end marker |
| src_dry | input | 1 | Buffer manager has no more data for this frame |
| refill_req | output | 1 | Request more data from the buffer manager |
| tx_go | output | 1 | One-cycle start pulse to the MAC |

## Verification
`refill_req` passes through one register, so it follows `free_bytes`, `src_dry` and the latched code exactly one edge later. The bench drives inputs on the falling edge and samples after the next rising edge. A start caused by the byte threshold passes through two registers: the count register, then the pulse register. The bench therefore records the byte total that stood before each edge and expects the pulse when that total first equals the threshold. A start caused by the tail flag takes one register, so the pulse is expected at the very edge where the flag is first seen.

// File: rtl/txq_pacer_pkg.sv
package txq_pacer_pkg;

  localparam logic [1:0] WM_RESET_CODE = 2'b00;
  localparam logic [1:0] SP_RESET_CODE = 2'b10;

  // refill threshold in 16-bit word slots; code 11 is reserved and folds onto 00
  function automatic int unsigned wm_slots(input logic [1:0] code);
    case (code)
      2'b01:   return 8;
      2'b10:   return 16;
      default: return 4;
    endcase
  endfunction

  // start threshold in bytes of the current frame
  function automatic int unsigned sp_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 4;
      2'b01:   return 16;
      2'b10:   return 64;
      default: return 112;
    endcase
  endfunction

endpackage

// File: rtl/txq_cfg_regs.sv
module txq_cfg_regs
  import txq_pacer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] wm_sel,
  input  logic [1:0] sp_sel,
  output logic [1:0] wm_code,
  output logic [1:0] sp_code
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wm_code <= WM_RESET_CODE;
      sp_code <= SP_RESET_CODE;
    end else if (cfg_we) begin
      wm_code <= wm_sel;
      sp_code <= sp_sel;
    end
  end

  // R8: codes only move under the write strobe
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(wm_code) && $stable(sp_code)));

endmodule

// File: rtl/txq_refill_gen.sv
module txq_refill_gen
  import txq_pacer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] free_bytes,
  input  logic [1:0]       wm_code,
  input  logic             src_dry,
  output logic             refill_req
);

  logic [CNT_W-1:0] slot_free;
  logic [CNT_W-1:0] slot_need;
  logic             room_ok;

  assign slot_free = free_bytes >> 1;
  assign slot_need = CNT_W'(wm_slots(wm_code));
  assign room_ok   = (slot_free >= slot_need);

  always_ff @(posedge clk) begin
    if (!rst_n) refill_req <= 1'b0;
    else        refill_req <= room_ok && !src_dry;
  end

  // R6: a dry source silences the request on the next cycle
  p_dry_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    src_dry |=> !refill_req);

  // R1: a request never appears without at least the smallest window of room
  p_room_min_r1: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> ($past(free_bytes) >= CNT_W'(8)));

endmodule

// File: rtl/txq_start_gen.sv
module txq_start_gen
  import txq_pacer_pkg::*;
#(
  parameter int FRM_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] push_bytes,
  input  logic       frame_tail_in,
  input  logic       eof_taken,
  input  logic [1:0] sp_code,
  output logic       tx_go
);

  localparam logic [FRM_W-1:0] CNT_MAX = '1;

  logic [FRM_W-1:0] frm_cnt;
  logic [FRM_W:0]   cnt_sum;
  logic [FRM_W-1:0] cnt_next;
  logic [FRM_W-1:0] thr_bytes;
  logic             started;
  logic             reach_thr;
  logic             go_cond;

  assign cnt_sum   = {1'b0, frm_cnt} + (FRM_W+1)'(push_bytes);
  assign cnt_next  = cnt_sum[FRM_W] ? CNT_MAX : cnt_sum[FRM_W-1:0];
  assign thr_bytes = FRM_W'(sp_bytes(sp_code));
  assign reach_thr = (frm_cnt >= thr_bytes);
  assign go_cond   = !started && !eof_taken && (reach_thr || frame_tail_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_cnt <= '0;
      started <= 1'b0;
      tx_go   <= 1'b0;
    end else begin
      frm_cnt <= eof_taken ? FRM_W'(push_bytes) : cnt_next;
      started <= eof_taken ? 1'b0 : (started || go_cond);
      tx_go   <= go_cond;
    end
  end

  // R5: the start is a single-cycle pulse
  p_go_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> !tx_go);

  // R5: once a frame has started, no new pulse until it is closed
  p_go_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !eof_taken) |=> !tx_go);

  // R3/R4: a pulse has a cause, either the tail flag or at least the smallest threshold
  p_go_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> ($past(frame_tail_in) || ($past(frm_cnt) >= FRM_W'(4))));

endmodule

// File: rtl/txq_pacer.sv
module txq_pacer
  import txq_pacer_pkg::*;
#(
  parameter int FIFO_BYTES = 128,
  parameter int FRM_W      = 12,
  localparam int CNT_W     = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       wm_sel,
  input  logic [1:0]       sp_sel,
  input  logic [CNT_W-1:0] free_bytes,
  input  logic [1:0]       push_bytes,
  input  logic             frame_tail_in,
  input  logic             eof_taken,
  input  logic             src_dry,
  output logic             refill_req,
  output logic             tx_go
);

  logic [1:0] wm_code;
  logic [1:0] sp_code;

  txq_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .wm_sel  (wm_sel),
    .sp_sel  (sp_sel),
    .wm_code (wm_code),
    .sp_code (sp_code)
  );

  txq_refill_gen #(.CNT_W(CNT_W)) u_refill (
    .clk        (clk),
    .rst_n      (rst_n),
    .free_bytes (free_bytes),
    .wm_code    (wm_code),
    .src_dry    (src_dry),
    .refill_req (refill_req)
  );

  txq_start_gen #(.FRM_W(FRM_W)) u_start (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_bytes    (push_bytes),
    .frame_tail_in (frame_tail_in),
    .eof_taken     (eof_taken),
    .sp_code       (sp_code),
    .tx_go         (tx_go)
  );

endmodule

// File: tb/txq_pacer_bench.sv
module txq_pacer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n, cfg_we, frame_tail_in, eof_taken, src_dry;
  logic [1:0] wm_sel, sp_sel, push_bytes;
  logic [CNT_W-1:0] free_bytes;
  logic refill_req, tx_go;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_pacer u_txq_pacer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .wm_sel(wm_sel), .sp_sel(sp_sel),
    .free_bytes(free_bytes), .push_bytes(push_bytes), .frame_tail_in(frame_tail_in),
    .eof_taken(eof_taken), .src_dry(src_dry), .refill_req(refill_req), .tx_go(tx_go)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int room_bytes(input logic [1:0] wm);
    if (wm == 2'b01) return 16;
    if (wm == 2'b10) return 32;
    return 8;
  endfunction

  task automatic set_cfg(input logic [1:0] wm, input logic [1:0] sp);
    wm_sel = wm; sp_sel = sp; cfg_we = 1'b1;
    tick;
    cfg_we = 1'b0;
  endtask

  task automatic refill_case(input logic [1:0] wm, input int free, input bit dry, input string req);
    int exp;
    free_bytes = CNT_W'(free); src_dry = dry;
    tick;
    exp = (!dry && free >= room_bytes(wm)) ? 1 : 0;
    chk(int'(refill_req) == exp, req, $sformatf("refill wm=%0d free=%0d dry=%0d", wm, free, dry),
        int'(refill_req), exp);
  endtask

  task automatic end_frame;
    push_bytes = 2'd0; frame_tail_in = 1'b0; eof_taken = 1'b1;
    tick;
    eof_taken = 1'b0;
    tick;
  endtask

  // pushes one byte per cycle; records the byte total that stood before the pulse edge
  task automatic run_frame(input int nbytes, input bit tail, input int exp_at, input string req);
    int total = 0;
    int go_at = -1;
    int pulses = 0;
    for (int k = 0; k < nbytes + 6; k++) begin
      push_bytes = (total < nbytes) ? 2'd1 : 2'd0;
      frame_tail_in = tail && (total >= nbytes);
      tick;
      if (tx_go) begin
        pulses++;
        if (go_at < 0) go_at = total;
      end
      total += int'(push_bytes);
    end
    push_bytes = 2'd0; frame_tail_in = 1'b0;
    chk(go_at == exp_at, req, "start point (bytes)", go_at, exp_at);
    chk(pulses == ((exp_at < 0) ? 0 : 1), "R5", "pulses per frame", pulses, (exp_at < 0) ? 0 : 1);
    end_frame;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cfg_we = 1'b0; wm_sel = 2'b11; sp_sel = 2'b00;
    free_bytes = '0; push_bytes = 2'd0; frame_tail_in = 1'b0; eof_taken = 1'b0; src_dry = 1'b0;
    tick; tick;
    rst_n = 1'b1;
    tick;
    chk(refill_req == 1'b0, "R7", "refill after reset", int'(refill_req), 0);
    chk(tx_go == 1'b0, "R7", "tx_go after reset", int'(tx_go), 0);
    // R7 default start code 10 -> 64 bytes
    run_frame(70, 1'b0, 64, "R7");
    // R7 default refill code 00 -> 8 bytes
    refill_case(2'b00, 8, 1'b0, "R7");
    refill_case(2'b00, 7, 1'b0, "R7");
  endtask

  task automatic t_thresholds;
    set_cfg(2'b00, 2'b00);
    run_frame(10, 1'b0, 4, "R3");
    set_cfg(2'b00, 2'b01);
    run_frame(20, 1'b0, 16, "R3");
    set_cfg(2'b00, 2'b11);
    run_frame(115, 1'b0, 112, "R3");
    run_frame(100, 1'b0, -1, "R3");
  endtask

  task automatic t_tail;
    set_cfg(2'b00, 2'b11);
    run_frame(20, 1'b1, 20, "R4");
    set_cfg(2'b00, 2'b10);
    run_frame(1, 1'b1, 1, "R4");
    // R5: threshold crossed first, later tail gives no second pulse
    set_cfg(2'b00, 2'b00);
    run_frame(30, 1'b1, 4, "R5");
  endtask

  task automatic t_eof_restart;
    set_cfg(2'b00, 2'b00);
    push_bytes = 2'd1; tick; tick;
    eof_taken = 1'b1; push_bytes = 2'd2; tick;
    eof_taken = 1'b0; push_bytes = 2'd0; tick;
    chk(tx_go == 1'b0, "R9", "no start from old-frame bytes", int'(tx_go), 0);
    push_bytes = 2'd2; tick;
    chk(tx_go == 1'b0, "R9", "count 2 below threshold", int'(tx_go), 0);
    push_bytes = 2'd0; tick;
    chk(tx_go == 1'b1, "R9", "start at 4 incl. eof-cycle bytes", int'(tx_go), 1);
    end_frame;
  endtask

  task automatic t_refill;
    set_cfg(2'b01, 2'b10);
    refill_case(2'b01, 16, 1'b0, "R1");
    refill_case(2'b01, 15, 1'b0, "R1");
    set_cfg(2'b10, 2'b10);
    refill_case(2'b10, 32, 1'b0, "R1");
    refill_case(2'b10, 31, 1'b0, "R1");
    refill_case(2'b10, 128, 1'b1, "R6");
    refill_case(2'b10, 128, 1'b0, "R1");
    set_cfg(2'b11, 2'b10);
    refill_case(2'b11, 8, 1'b0, "R2");
    refill_case(2'b11, 7, 1'b0, "R2");
    // R8: selection change without strobe is ignored (still code 11 -> 8 bytes)
    wm_sel = 2'b10;
    refill_case(2'b11, 10, 1'b0, "R8");
    set_cfg(2'b10, 2'b10);
    refill_case(2'b10, 10, 1'b0, "R8");
  endtask

  initial begin
    t_reset;
    t_thresholds;
    t_tail;
    t_eof_restart;
    t_refill;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule